// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Column Sequencer

This block holds the programmable mode word of a synchronous DRAM controller and turns each read or write command into the column addresses of its burst. A mode-set strobe loads the word from the 14-bit address bus. The word is decoded into four settings: the burst length, the burst order, the CAS latency and the operating mode. The latency is passed out for the data path to use. Any reserved or contradictory setting raises an error flag. While that flag is up, commands are refused.

When a command is accepted, the sequencer puts out one column per clock, starting on the next cycle. A fixed-length burst of 2, 4 or 8 beats stays inside an aligned block of columns. It walks that block in either sequential (wrapping) or interleaved (XOR) order. A full-page burst walks the whole page and wraps at a page size that is supplied at run time. When the write-through-cache mode is selected, every write is cut to one beat, while reads keep the programmed length. A new command always takes over from the burst in progress.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is held and after it is released, beat_valid, beat_last and burst_done are 0. The mode word resets to 14'h0020 (CAS latency 2, one beat, sequential, normal), so cas_lat reads 2 and mode_err reads 0.
- R2: On a clock edge with mrs_stb high, the mode word is loaded from addr[13:0]. From the next cycle, cas_lat shows 2 for latency field addr[6:4]=3'b010, 3 for 3'b011, and 0 for any other code.
- R3: mode_err is 1 if any of the following holds. The length field addr[2:0] is 3'b100, 3'b101 or 3'b110. The length field is 3'b111 (full page) while addr[3]=1 (interleaved). The latency code is reserved. The operating-mode field addr[13:7] is neither 0 (normal) nor 7'b0000100 (single write, bit 9 set).
- R4: A command is accepted at an edge where rd_stb or wr_stb is high and mode_err is 0. Its first beat shows start_col on the next cycle, and later beats follow on consecutive cycles. Commands given while mode_err is 1 produce no beats.
- R5: With addr[3]=0 and length codes 3'b001, 3'b011 or 3'b010 (2, 8 or 4 beats), beat i has the upper column bits of start_col and low bits (start_col + i) mod N.
- R6: With addr[3]=1, beat i has the upper bits of start_col and low bits (start_col XOR i) over the low log2(N) bits.
- R7: Length code 3'b111 gives page_size beats, with beat i at column (start_col + i) mod page_size. This assumes start_col < page_size and 1 <= page_size <= 2^COL_W.
- R8: In single-write mode, a write produces exactly one beat at start_col, and a read uses the programmed length.
- R9: beat_last is high only on the final beat of a burst. burst_done pulses for one cycle after the final beat, unless a command is accepted at that edge.
- R10: A command accepted while a burst is running abandons that burst, and the new burst's first beat appears on the next cycle.
- R11: If rd_stb and wr_stb are both high, the command is treated as a read. A command given in the same cycle as mrs_stb uses the mode word held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mrs_stb | input | 1 | Load mode word from addr |
| addr | input | 14 | Address bus carrying the mode word |
| rd_stb | input | 1 | Read command |
| wr_stb | input | 1 | Write command |
| start_col | input | COL_W | Starting column of the command |
| page_size | input | COL_W+1 | Columns per page for full-page bursts |
| beat_col | output | COL_W | Column of the current beat |
| beat_valid | output | 1 | A beat is being presented |
| beat_last | output | 1 | Current beat is the final one |
| burst_done | output | 1 | One-cycle pulse after a burst completes |
| cas_lat | output | 3 | Decoded CAS latency (0 if reserved) |
| mode_err | output | 1 | Mode word is illegal |

## Verification
Two pairs of events can fall on the same edge, and the stimulus forces both. The first pair is a new command landing on the final beat of a burst: here burst_done must stay low and the new start column must appear on the next cycle. The second pair is a mode-set strobe given together with a command: here the burst must follow the old length and order, while cas_lat and mode_err move to the new word. A behavioural model in the bench rebuilds the expected column list for every accepted command and compares valid, column, last, done, latency and error on every cycle. It also covers these collisions.

// File: rtl/sdram_burst_pkg.sv
// Package: shared mode-configuration type and constants for the burst sequencer.
// Assumes a 14-bit mode word with the field layout fixed by the DRAM protocol.
package sdram_burst_pkg;

    localparam int MODE_W = 14;
    localparam logic [MODE_W-1:0] MODE_RESET = 14'h0020;
    localparam logic [6:0] OPM_SINGLE_WR = 7'b0000100;

    // Decoded view of the mode word, consumed by the burst controller.
    typedef struct packed {
        logic       interleave;
        logic       full_page;
        logic [3:0] fixed_len;
        logic       single_wr;
        logic       illegal;
        logic [2:0] cas;
    } mode_cfg_t;

endpackage

// File: rtl/sbs_mode_reg.sv
// Module: holds the mode word and decodes it into a mode_cfg_t.
// Assumes the word is loaded only on mrs; the decoded view follows the
// stored word combinationally, so it changes the cycle after a load.
module sbs_mode_reg
    import sdram_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] word_in,
    output mode_cfg_t         cfg
);

    logic [MODE_W-1:0] word_q;
    logic [2:0]        len_code;
    logic [2:0]        lat_code;
    logic [6:0]        op_code;
    logic              len_ok;
    logic              op_ok;

    // Store the mode word on a mode-set strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= MODE_RESET;
        end else if (load) begin
            word_q <= word_in;
        end
    end

    assign len_code = word_q[2:0];
    assign lat_code = word_q[6:4];
    assign op_code  = word_q[13:7];

    // Decode the length, order, latency and operating-mode fields.
    always_comb begin
        cfg            = '0;
        cfg.interleave = word_q[3];
        len_ok         = 1'b1;
        unique case (len_code)
            3'b000:  cfg.fixed_len = 4'd1;
            3'b001:  cfg.fixed_len = 4'd2;
            3'b010:  cfg.fixed_len = 4'd4;
            3'b011:  cfg.fixed_len = 4'd8;
            3'b111: begin
                cfg.fixed_len = 4'd1;
                cfg.full_page = 1'b1;
            end
            default: begin
                cfg.fixed_len = 4'd1;
                len_ok        = 1'b0;
            end
        endcase
        unique case (lat_code)
            3'b010:  cfg.cas = 3'd2;
            3'b011:  cfg.cas = 3'd3;
            default: cfg.cas = 3'd0;
        endcase
        op_ok         = (op_code == 7'd0) || (op_code == OPM_SINGLE_WR);
        cfg.single_wr = (op_code == OPM_SINGLE_WR);
        cfg.illegal   = !len_ok || !op_ok || (cfg.cas == 3'd0)
                      || (cfg.full_page && cfg.interleave);
    end

    // R3: a legal decoded mode never pairs full page with interleaved order
    p_full_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.full_page && !cfg.illegal) |-> !cfg.interleave);

    // R2: a legal mode always carries one of the two supported latencies
    p_cas_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.illegal |-> (cfg.cas == 3'd2 || cfg.cas == 3'd3));

endmodule

// File: rtl/sbs_col_gen.sv
// Module: combinational column generator for one beat of a burst.
// Assumes fixed lengths are powers of two up to 8, base < page and
// idx < page for full-page bursts.
module sbs_col_gen #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W:0]   idx,
    input  logic [COL_W:0]   len,
    input  logic             interleave,
    input  logic             full_page,
    input  logic [COL_W:0]   page,
    output logic [COL_W-1:0] col
);

    localparam int PW = COL_W + 1;

    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_itl;
    logic [PW-1:0]    page_sum;
    logic [PW-1:0]    page_wrap;

    // Mask selecting the low bits that rotate within an aligned block.
    assign mask = len[COL_W-1:0] - COL_W'(1);

    // Candidate low bits for each order.
    assign low_seq = (base + idx[COL_W-1:0]) & mask;
    assign low_itl = (base ^ idx[COL_W-1:0]) & mask;

    // Full-page position with a single wrap at the page size.
    always_comb begin
        page_sum  = {1'b0, base} + idx;
        page_wrap = (page_sum >= page) ? (page_sum - page) : page_sum;
    end

    // Pick the column for the active burst kind.
    always_comb begin
        if (full_page) begin
            col = page_wrap[COL_W-1:0];
        end else if (interleave) begin
            col = (base & ~mask) | low_itl;
        end else begin
            col = (base & ~mask) | low_seq;
        end
    end

endmodule

// File: rtl/sbs_burst_ctrl.sv
// Module: accepts read/write commands and counts beats of the burst.
// Assumes cfg reflects the mode held before the current edge; the burst
// latches its own length and order so a later mode change cannot alter it.
module sbs_burst_ctrl
    import sdram_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd,
    input  logic             wr,
    input  mode_cfg_t        cfg,
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W:0]   page_size,
    output logic             active,
    output logic [COL_W:0]   idx,
    output logic [COL_W-1:0] base,
    output logic [COL_W:0]   len,
    output logic             interleave_q,
    output logic             full_q,
    output logic [COL_W:0]   page_q,
    output logic             last,
    output logic             done
);

    localparam int PW = COL_W + 1;

    logic          accept;
    logic          is_write;
    logic          force_one;
    logic [PW-1:0] new_len;

    // Work out the command acceptance and the length of the new burst.
    always_comb begin
        accept    = (rd || wr) && !cfg.illegal;
        is_write  = wr && !rd;
        force_one = is_write && cfg.single_wr;
        if (force_one) begin
            new_len = PW'(1);
        end else if (cfg.full_page) begin
            new_len = page_size;
        end else begin
            new_len = PW'(cfg.fixed_len);
        end
    end

    assign last = active && (idx == len - PW'(1));

    // Start, advance and finish bursts; a new command always wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active       <= 1'b0;
            idx          <= '0;
            base         <= '0;
            len          <= PW'(1);
            interleave_q <= 1'b0;
            full_q       <= 1'b0;
            page_q       <= '0;
            done         <= 1'b0;
        end else begin
            done <= last && !accept;
            if (accept) begin
                active       <= 1'b1;
                idx          <= '0;
                base         <= start_col;
                len          <= new_len;
                interleave_q <= cfg.interleave;
                full_q       <= cfg.full_page && !force_one;
                page_q       <= page_size;
            end else if (active) begin
                if (last) begin
                    active <= 1'b0;
                end else begin
                    idx <= idx + PW'(1);
                end
            end
        end
    end

    // R9: the beat index never runs past the latched length
    p_idx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx < len));

    // R8: a write in single-write mode ends on its first beat
    p_single_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !rd && !cfg.illegal && cfg.single_wr) |=> last);

endmodule

// File: rtl/sdram_burst_seq.sv
// Module: top of the SDRAM mode register and burst column sequencer.
// Assumes 1 <= page_size <= 2**COL_W and start_col < page_size for
// full-page bursts; COL_W must be at least 3 to hold an 8-beat block.
module sdram_burst_seq
    import sdram_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_stb,
    input  logic [MODE_W-1:0] addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [COL_W-1:0]  start_col,
    input  logic [COL_W:0]    page_size,
    output logic [COL_W-1:0]  beat_col,
    output logic              beat_valid,
    output logic              beat_last,
    output logic              burst_done,
    output logic [2:0]        cas_lat,
    output logic              mode_err
);

    mode_cfg_t        cfg;
    logic             active;
    logic [COL_W:0]   idx;
    logic [COL_W-1:0] base;
    logic [COL_W:0]   len;
    logic             itl_q;
    logic             full_q;
    logic [COL_W:0]   page_q;
    logic             last;
    logic             done;
    logic [COL_W-1:0] col;

    sbs_mode_reg i_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (mrs_stb),
        .word_in (addr),
        .cfg     (cfg)
    );

    sbs_burst_ctrl #(.COL_W(COL_W)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd           (rd_stb),
        .wr           (wr_stb),
        .cfg          (cfg),
        .start_col    (start_col),
        .page_size    (page_size),
        .active       (active),
        .idx          (idx),
        .base         (base),
        .len          (len),
        .interleave_q (itl_q),
        .full_q       (full_q),
        .page_q       (page_q),
        .last         (last),
        .done         (done)
    );

    sbs_col_gen #(.COL_W(COL_W)) i_col (
        .base       (base),
        .idx        (idx),
        .len        (len),
        .interleave (itl_q),
        .full_page  (full_q),
        .page       (page_q),
        .col        (col)
    );

    // Drive the beat outputs, holding the column at zero when idle.
    always_comb begin
        beat_valid = active;
        beat_col   = active ? col : '0;
        beat_last  = last;
        burst_done = done;
        cas_lat    = cfg.cas;
        mode_err   = cfg.illegal;
    end

    // R4: an accepted command shows its start column on the next cycle
    p_first_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_stb || wr_stb) && !mode_err) |=> (beat_valid && beat_col == $past(start_col)));

    // R4: a refused command starts nothing when the sequencer is idle
    p_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_stb || wr_stb) && mode_err && !beat_valid) |=> !beat_valid);

    // R9: last only appears on a presented beat
    p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

    // R9: done follows a final beat and leaves the sequencer idle
    p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> (!beat_valid && $past(beat_last)));

    // R2: loading latency code 3 reports latency 3 on the next cycle
    p_mrs_cas_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_stb && addr[6:4] == 3'b011) |=> (cas_lat == 3'd3));

endmodule

// File: tb/test_sdram_burst_seq.sv
module test_sdram_burst_seq;

    localparam int COL_W = 10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              mrs_stb;
    logic [13:0]       addr;
    logic              rd_stb;
    logic              wr_stb;
    logic [COL_W-1:0]  start_col;
    logic [COL_W:0]    page_size;
    logic [COL_W-1:0]  beat_col;
    logic              beat_valid;
    logic              beat_last;
    logic              burst_done;
    logic [2:0]        cas_lat;
    logic              mode_err;

    int    checks = 0;
    int    fails = 0;
    string req = "R1";
    bit    finished = 0;

    int          q[$];
    logic [13:0] mw;
    bit          exp_done;

    always #5 clk = ~clk;

    sdram_burst_seq #(.COL_W(COL_W)) i_sdram_burst_seq (
        .clk(clk), .rst_n(rst_n), .mrs_stb(mrs_stb), .addr(addr),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .start_col(start_col),
        .page_size(page_size), .beat_col(beat_col), .beat_valid(beat_valid),
        .beat_last(beat_last), .burst_done(burst_done), .cas_lat(cas_lat),
        .mode_err(mode_err)
    );

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit m_err(logic [13:0] w);
        bit bad_len = (w[2:0] == 3'd4) || (w[2:0] == 3'd5) || (w[2:0] == 3'd6);
        bit bad_fp  = (w[2:0] == 3'd7) && w[3];
        bit bad_cl  = !((w[6:4] == 3'd2) || (w[6:4] == 3'd3));
        bit bad_op  = !((w[13:7] == 7'd0) || (w[13:7] == 7'd4));
        return bad_len || bad_fp || bad_cl || bad_op;
    endfunction

    function automatic int m_cas(logic [13:0] w);
        if (w[6:4] == 3'd2) return 2;
        if (w[6:4] == 3'd3) return 3;
        return 0;
    endfunction

    // Build the expected column list for a command under mode word w.
    task automatic build(logic [13:0] w, bit is_wr, int s, int page);
        int n;
        q.delete();
        if (is_wr && w[13:7] == 7'd4) begin
            q.push_back(s);
        end else if (w[2:0] == 3'd7) begin
            for (int i = 0; i < page; i++) q.push_back((s + i) % page);
        end else begin
            int base, lo;
            n    = 1 << w[2:0];
            lo   = s % n;
            base = s - lo;
            for (int i = 0; i < n; i++) begin
                if (w[3]) q.push_back(base + (lo ^ i));
                else      q.push_back(base + ((lo + i) % n));
            end
        end
    endtask

    // Reference model: advance on each edge, then compare outputs.
    always @(posedge clk) begin
        bit acc;
        bit was_last;
        if (!rst_n) begin
            mw = 14'h0020;
            q.delete();
            exp_done = 0;
        end else begin
            acc      = (rd_stb || wr_stb) && !m_err(mw);
            was_last = (q.size() == 1);
            if (q.size() > 0) void'(q.pop_front());
            exp_done = was_last && !acc;
            if (acc) build(mw, wr_stb && !rd_stb, int'(start_col), int'(page_size));
            if (mrs_stb) mw = addr;
        end
        #2;
        if (!finished) begin
            chk("valid", int'(beat_valid), int'(q.size() > 0));
            if (q.size() > 0) begin
                chk("col", int'(beat_col), q[0]);
                chk("last", int'(beat_last), int'(q.size() == 1));
            end else begin
                chk("last_idle", int'(beat_last), 0);
            end
            chk("done", int'(burst_done), int'(exp_done));
            chk("cas", int'(cas_lat), m_cas(mw));
            chk("err", int'(mode_err), int'(m_err(mw)));
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(bit r, bit w, int s);
        @(negedge clk);
        rd_stb = r; wr_stb = w; start_col = COL_W'(s);
        @(negedge clk);
        rd_stb = 0; wr_stb = 0;
    endtask

    task automatic mrs(logic [13:0] a);
        @(negedge clk);
        mrs_stb = 1; addr = a;
        @(negedge clk);
        mrs_stb = 0;
    endtask

    initial begin
        rst_n = 0; mrs_stb = 0; addr = '0; rd_stb = 0; wr_stb = 0;
        start_col = '0; page_size = 11'd1024;
        idle(3);
        req = "R1"; rst_n = 1; idle(2);
        req = "R4"; cmd(1, 0, 37); idle(3);
        req = "R5"; mrs(14'h0032); cmd(1, 0, 10'h1F6); idle(6);
        mrs(14'h0033); cmd(1, 0, 10'h00D); idle(10);
        mrs(14'h0031); cmd(0, 1, 10'h3FF); idle(4);
        req = "R6"; mrs(14'h003B); cmd(1, 0, 10'h015); idle(10);
        mrs(14'h003A); cmd(0, 1, 10'h2C6); idle(6);
        req = "R7"; page_size = 11'd16; mrs(14'h0037); cmd(1, 0, 13); idle(20);
        page_size = 11'd1024;
        req = "R3"; mrs(14'h003F); idle(2);
        req = "R4"; cmd(1, 0, 5); cmd(0, 1, 6); idle(3);
        req = "R3"; mrs(14'h0034); idle(2); mrs(14'h0012); idle(2);
        mrs(14'h00B2); idle(2); mrs(14'h0432); idle(2);
        req = "R8"; mrs(14'h0233); cmd(0, 1, 5); idle(3); cmd(1, 0, 21); idle(10);
        req = "R10"; mrs(14'h0033); cmd(1, 0, 40); idle(2); cmd(0, 1, 100); idle(10);
        req = "R9"; mrs(14'h0032); cmd(1, 0, 8); idle(2); cmd(1, 0, 50); idle(6);
        req = "R11"; mrs(14'h0233); cmd(1, 1, 9); idle(10);
        @(negedge clk);
        mrs_stb = 1; addr = 14'h0031; rd_stb = 1; start_col = 10'h0A3;
        @(negedge clk);
        mrs_stb = 0; rd_stb = 0;
        idle(10);
        cmd(1, 0, 3); idle(4);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule